// File: doc/BRIEF.md
# Transmit Link-Layer Packet Framer

This block sits on the transmit side of a serial packet link. An upstream transaction layer hands it a packet one 32-bit dword at a time. The dwords are the header (3 or 4 dwords), an optional data payload of 0 to 1024 dwords, and an optional end-to-end CRC dword. Upstream places them in that order and marks the final dword with a last flag. The framer turns the packet into a byte stream and sends it out over a valid/ready interface.

Each outgoing frame has a fixed layout. It opens with a start control symbol, followed by a two-byte sequence field. The packet bytes come next, unchanged. A four-byte link CRC follows, and an end control symbol closes the frame. The framer owns the 12-bit transmit sequence counter. It also owns the running link CRC, which covers the sequence field and the packet bytes but neither control symbol.

The controller is a state machine with these states:
- `ST_IDLE` waits for a packet and goes to `ST_START` when input is valid.
- `ST_START` sends the start symbol and goes to `ST_SEQ_HI`.
- `ST_SEQ_HI` sends the upper sequence byte and goes to `ST_SEQ_LO`.
- `ST_SEQ_LO` sends the lower sequence byte. It takes the first dword directly into `ST_BODY`, or goes to `ST_FETCH` if no dword is ready.
- `ST_FETCH` waits with the output idle until a dword arrives, then goes to `ST_BODY`.
- `ST_BODY` sends four bytes per dword. After the fourth byte it takes the next dword in place, or goes to `ST_FETCH`, or goes to `ST_LCRC` if the dword was marked last.
- `ST_LCRC` sends four CRC bytes and goes to `ST_END`.
- `ST_END` sends the end symbol, advances the sequence counter and returns to `ST_IDLE`.

Top module: `tlp_link_framer`

## Requirements
- R1: After reset, out_valid and in_ready are 0, and the first frame carries sequence number 0.
- R2: A frame is, in order: start symbol, sequence field (2 bytes), every input dword of the packet, link CRC (4 bytes), end symbol. Its length is 8 + 4·N bytes for N input dwords. The framer takes no input dword while it shows a control symbol.
- R3: The start symbol is byte 0xFB and the end symbol is byte 0xFD, each with out_k = 1. Every other byte has out_k = 0.
- R4: The sequence field is sent upper byte first. Its upper 4 bits are 0 and its lower 12 bits are the sequence number.
- R5: The sequence number increases by 1 for each frame, wrapping from 4095 to 0. It changes only in the cycle after the end symbol is accepted.
- R6: Each input dword is sent most significant byte first (bits 31:24 first) and is otherwise unchanged. Packets of any length from 1 dword up to 1029 dwords are framed.
- R7: The link CRC is CRC-32 with polynomial 0x04C11DB7. It uses initial value 0xFFFFFFFF, processes each byte from bit 7 down to bit 0, and complements the result. It covers the two sequence bytes and all packet bytes, and is sent bits 31:24 first.
- R8: While out_valid is 1 and out_ready is 0, the next cycle keeps out_valid, out_byte and out_k unchanged. No byte is dropped or repeated under any pattern of backpressure or input gaps.
- R9: With no input offered after a frame, out_valid stays 0 and no byte is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream dword is valid |
| in_ready | output | 1 | Framer takes the dword this cycle |
| in_data | input | 32 | Packet dword |
| in_last | input | 1 | Marks the final dword of a packet |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the byte this cycle |
| out_byte | output | 8 | Frame byte |
| out_k | output | 1 | Byte is a control symbol |

## Verification
The hardest state to reach is the sequence wrap from 4095 to 0. It only occurs after four thousand complete frames. The bench reaches it with a long run of one-dword packets under full readiness, and checks the sequence bytes of every frame so the wrap frame is covered. Mixed with this are random-length packets, including the 1029-dword maximum, under random input gaps and random output stalls. These make the framer hit `ST_FETCH` at every dword boundary and hold bytes during both control symbols and CRC bytes.

// File: rtl/tlpf_pkg.sv
package tlpf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEQ_HI,
        ST_SEQ_LO,
        ST_FETCH,
        ST_BODY,
        ST_LCRC,
        ST_END
    } tlpf_state_e;

    localparam logic [7:0]  SYM_START = 8'hFB;
    localparam logic [7:0]  SYM_END   = 8'hFD;
    localparam int          CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
    localparam int          SEQ_FIELD_W = 16;

endpackage

// File: rtl/tlpf_seq_ctr.sv
module tlpf_seq_ctr #(
    parameter int SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SEQ_W-1:0] seq
);
    always_ff @(posedge clk) begin
        if (!rst_n)   seq <= '0;
        else if (adv) seq <= seq + 1'b1;
    end
endmodule

// File: rtl/tlpf_crc32.sv
module tlpf_crc32
    import tlpf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc
);
    function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                              input logic [7:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= CRC_SEED;
        else if (en)         crc <= step(crc, din);
    end
endmodule

// File: rtl/tlpf_word_hold.sv
module tlpf_word_hold #(
    parameter int DW    = 32,
    parameter int BPW   = DW / 8,
    parameter int SEL_W = $clog2(BPW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    din,
    input  logic             last_in,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       byte_out,
    output logic             last_out
);
    logic [DW-1:0] word_q;
    logic [7:0]    lanes [BPW];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            last_out <= 1'b0;
        end else if (load) begin
            word_q   <= din;
            last_out <= last_in;
        end
    end

    for (genvar g = 0; g < BPW; g++) begin : g_lane
        assign lanes[g] = word_q[DW-1-8*g -: 8];
    end

    assign byte_out = lanes[sel];
endmodule

// File: rtl/tlp_link_framer.sv
module tlp_link_framer
    import tlpf_pkg::*;
#(
    parameter int SEQ_W = 12,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_byte,
    output logic          out_k
);
    localparam int BPW      = DW / 8;
    localparam int CRC_B    = CRC_W / 8;
    localparam int IDX_W    = $clog2((BPW > CRC_B) ? BPW : CRC_B);
    localparam logic [IDX_W-1:0] WORD_LAST = IDX_W'(BPW - 1);
    localparam logic [IDX_W-1:0] CRC_LAST  = IDX_W'(CRC_B - 1);

    tlpf_state_e          state, state_n;
    logic [IDX_W-1:0]     idx, idx_n;
    logic [SEQ_W-1:0]     seq_q;
    logic [SEQ_FIELD_W-1:0] seq_field;
    logic                 accept, load, seq_adv, crc_clr, crc_en;
    logic [CRC_W-1:0]     crc_run, crc_fin;
    logic [7:0]           crc_bytes [CRC_B];
    logic [7:0]           body_byte;
    logic                 body_last;

    tlpf_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(seq_adv), .seq(seq_q)
    );

    tlpf_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en),
        .din(out_byte), .crc(crc_run)
    );

    tlpf_word_hold #(.DW(DW), .BPW(BPW), .SEL_W(IDX_W)) u_word (
        .clk(clk), .rst_n(rst_n), .load(load), .din(in_data),
        .last_in(in_last), .sel(idx), .byte_out(body_byte),
        .last_out(body_last)
    );

    assign seq_field = SEQ_FIELD_W'(seq_q);
    assign crc_fin   = ~crc_run;
    for (genvar g = 0; g < CRC_B; g++) begin : g_crc_lane
        assign crc_bytes[g] = crc_fin[CRC_W-1-8*g -: 8];
    end

    assign accept  = out_valid && out_ready;
    assign crc_clr = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
        end
    end

    always_comb begin
        state_n   = state;
        idx_n     = idx;
        out_valid = 1'b0;
        out_k     = 1'b0;
        out_byte  = '0;
        in_ready  = 1'b0;
        load      = 1'b0;
        crc_en    = 1'b0;
        seq_adv   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) state_n = ST_START;
            end
            ST_START: begin
                out_valid = 1'b1;
                out_k     = 1'b1;
                out_byte  = SYM_START;
                if (accept) state_n = ST_SEQ_HI;
            end
            ST_SEQ_HI: begin
                out_valid = 1'b1;
                out_byte  = seq_field[15:8];
                if (accept) begin
                    crc_en  = 1'b1;
                    state_n = ST_SEQ_LO;
                end
            end
            ST_SEQ_LO: begin
                out_valid = 1'b1;
                out_byte  = seq_field[7:0];
                if (accept) begin
                    crc_en   = 1'b1;
                    in_ready = 1'b1;
                    idx_n    = '0;
                    if (in_valid) begin
                        load    = 1'b1;
                        state_n = ST_BODY;
                    end else begin
                        state_n = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    load    = 1'b1;
                    idx_n   = '0;
                    state_n = ST_BODY;
                end
            end
            ST_BODY: begin
                out_valid = 1'b1;
                out_byte  = body_byte;
                if (accept) begin
                    crc_en = 1'b1;
                    if (idx != WORD_LAST) begin
                        idx_n = idx + 1'b1;
                    end else if (body_last) begin
                        idx_n   = '0;
                        state_n = ST_LCRC;
                    end else begin
                        in_ready = 1'b1;
                        idx_n    = '0;
                        if (in_valid) load    = 1'b1;
                        else          state_n = ST_FETCH;
                    end
                end
            end
            ST_LCRC: begin
                out_valid = 1'b1;
                out_byte  = crc_bytes[idx];
                if (accept) begin
                    if (idx == CRC_LAST) begin
                        idx_n   = '0;
                        state_n = ST_END;
                    end else begin
                        idx_n = idx + 1'b1;
                    end
                end
            end
            ST_END: begin
                out_valid = 1'b1;
                out_k     = 1'b1;
                out_byte  = SYM_END;
                if (accept) begin
                    seq_adv = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/tlpf_checker.sv
module tlpf_checker
    import tlpf_pkg::*;
#(
    parameter int SEQ_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_byte,
    input logic             out_k,
    input logic [SEQ_W-1:0] seq
);
    logic end_taken;
    assign end_taken = out_valid && out_ready && out_k && (out_byte == SYM_END);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_k)));

    assert_ctrl_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_k) |-> (out_byte == SYM_START || out_byte == SYM_END));

    assert_no_take_on_symbol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_k) |-> !in_ready);

    assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        end_taken |=> (seq == ($past(seq) + {{(SEQ_W-1){1'b0}}, 1'b1})));

    assert_seq_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !end_taken |=> $stable(seq));
endmodule

bind tlp_link_framer tlpf_checker #(.SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_k(out_k), .seq(seq_q)
);

// File: tb/sim_tlp_link_framer.sv
`timescale 1ns/1ps
module sim_tlp_link_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        out_k;

    int errors = 0;
    int checks = 0;
    int in_gap = 0;
    int out_stall = 0;
    int hold_err = 0;
    int unsigned cycles = 0;
    logic [11:0] exp_seq = '0;

    logic [31:0] pkt [$];
    logic [8:0]  exp_q [$];
    logic [8:0]  got_q [$];

    always #10 clk = ~clk;

    tlp_link_framer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_byte(out_byte), .out_k(out_k)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [7:0] bytes [$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (bytes[n]) begin
            for (int b = 7; b >= 0; b--) begin
                logic top = c[31] ^ bytes[n][b];
                c = c << 1;
                if (top) c = c ^ 32'h04C1_1DB7;
            end
        end
        return ~c;
    endfunction

    task automatic build_expected();
        logic [7:0] cov [$];
        logic [31:0] lc;
        exp_q.delete();
        exp_q.push_back({1'b1, 8'hFB});
        cov.push_back({4'h0, exp_seq[11:8]});
        cov.push_back(exp_seq[7:0]);
        foreach (pkt[i])
            for (int j = 3; j >= 0; j--) cov.push_back(pkt[i][8*j +: 8]);
        foreach (cov[i]) exp_q.push_back({1'b0, cov[i]});
        lc = crc_ref(cov);
        for (int j = 3; j >= 0; j--) exp_q.push_back({1'b0, lc[8*j +: 8]});
        exp_q.push_back({1'b1, 8'hFD});
    endtask

    task automatic drive_pkt();
        foreach (pkt[i]) begin
            bit sent = 1'b0;
            while (!sent) begin
                @(negedge clk);
                in_valid = (($urandom % 100) >= in_gap);
                in_data  = pkt[i];
                in_last  = (i == pkt.size() - 1);
                #2;
                sent = in_valid && in_ready;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic watch_pkt();
        bit done = 1'b0;
        bit stalled = 1'b0;
        logic [8:0] held = '0;
        got_q.delete();
        hold_err = 0;
        while (!done) begin
            @(negedge clk);
            out_ready = (($urandom % 100) >= out_stall);
            #1;
            if (stalled && !(out_valid && {out_k, out_byte} == held)) hold_err++;
            stalled = out_valid && !out_ready;
            held    = {out_k, out_byte};
            if (out_valid && out_ready) begin
                got_q.push_back({out_k, out_byte});
                if (out_k && out_byte == 8'hFD) done = 1'b1;
            end
        end
    endtask

    task automatic run_pkt(input int ndw);
        int bad;
        int first_bad;
        int nb;
        pkt.delete();
        for (int i = 0; i < ndw; i++) pkt.push_back($urandom);
        build_expected();
        fork
            drive_pkt();
            watch_pkt();
        join
        chk(got_q.size() == exp_q.size(), "R2", "frame length",
            got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size()) begin
            nb = exp_q.size();
            chk(got_q[0] == exp_q[0] && got_q[nb-1] == exp_q[nb-1], "R3",
                "control symbols", {got_q[0], 7'd0, got_q[nb-1]},
                {exp_q[0], 7'd0, exp_q[nb-1]});
            chk(got_q[1] == exp_q[1] && got_q[2] == exp_q[2], "R4/R5",
                "sequence field", {got_q[1], got_q[2]}, {exp_q[1], exp_q[2]});
            bad = 0;
            first_bad = 0;
            for (int i = 3; i < nb - 5; i++)
                if (got_q[i] != exp_q[i]) begin
                    if (bad == 0) first_bad = i;
                    bad++;
                end
            chk(bad == 0, "R6", "packet bytes", got_q[first_bad], exp_q[first_bad]);
            chk({got_q[nb-5], got_q[nb-4], got_q[nb-3], got_q[nb-2]} ==
                {exp_q[nb-5], exp_q[nb-4], exp_q[nb-3], exp_q[nb-2]}, "R7",
                "link crc",
                {got_q[nb-5][7:0], got_q[nb-4][7:0], got_q[nb-3][7:0], got_q[nb-2][7:0]},
                {exp_q[nb-5][7:0], exp_q[nb-4][7:0], exp_q[nb-3][7:0], exp_q[nb-2][7:0]});
        end
        chk(hold_err == 0, "R8", "stall hold violations", hold_err, 0);
        exp_seq = exp_seq + 1'b1;
    endtask

    task automatic idle_check();
        int seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            if (out_valid) seen++;
        end
        chk(seen == 0, "R9", "output active with no input", seen, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !in_ready, "R1", "reset outputs",
            {out_valid, in_ready}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid && !in_ready, "R1", "idle after reset",
            {out_valid, in_ready}, 0);

        // R1 first frame seq 0; R6 minimum header lengths
        run_pkt(3);
        idle_check();
        run_pkt(4);
        // R8 with heavy stall and gaps
        in_gap = 40;
        out_stall = 50;
        run_pkt(5);
        idle_check();
        run_pkt(1);
        // R6 maximum: 4 header + 1024 payload + 1 end-to-end crc
        in_gap = 10;
        out_stall = 30;
        run_pkt(1029);
        for (int p = 0; p < 30; p++) begin
            in_gap = $urandom % 60;
            out_stall = $urandom % 60;
            run_pkt(3 + ($urandom % 40));
        end
        idle_check();
        // R5 wrap: run short packets past 4095 -> 0
        in_gap = 0;
        out_stall = 0;
        while (exp_seq != 12'd0) run_pkt(1);
        in_gap = 20;
        out_stall = 20;
        run_pkt(3);
        run_pkt(4);
        idle_check();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule